// File: doc/BRIEF.md
# Wiper Register Controller with Volatile and Stored Paths

This block holds the register set behind a 128-step digitally controlled resistor. It keeps a live wiper code that drives the resistor, a stored initial value that survives reset, and a control register. A serial front end hands it decoded read and write requests, and a commit strobe when chip select rises. All of these arrive as single-cycle pulses.

Address 0 is shared. A select bit in the control register chooses its meaning. When the bit is 1, address 0 is the live wiper register alone. When the bit is 0, a write to address 0 moves the live wiper at once and stages the value for the stored register. The next commit strobe programs the stored register and starts a busy period that models the slow programming cycle. During the busy period a read-only in-progress flag is set and all writes are refused. The block also drives an active-high shutdown output. It combines a control bit with an external run input.

Top module: `wiper_regfile`

## Requirements
- R1: After reset, ACR (address 2) reads 0x40: bit 7 (select) is 0, bit 6 (run) is 1 and bit 5 (busy) is 0. `shutdown` and `nv_busy` are 0.
- R2: When ACR bit 7 is 1, a write to address 0 sets `wiper_code` to data[6:0] on the next cycle. The stored value is left unchanged and no busy period starts.
- R3: When ACR bit 7 is 0, a write to address 0 sets `wiper_code` on the next cycle and stages the value. The next `commit` then writes it into the stored register and holds `nv_busy` high for exactly BUSY_TICKS cycles.
- R4: ACR bit 5 reads 1 while the busy period lasts and 0 otherwise. The bit 5 of write data is ignored.
- R5: While busy, writes to address 0 and to address 2 are ignored. `wiper_code` and the ACR read value do not change.
- R6: ACR bits 4:0 always read 0, whatever was written to them.
- R7: A read returns data on `rd_data` with `rd_valid` one cycle after the request. Address 0 returns {0, wiper} when bit 7 is 1 and {0, stored} when bit 7 is 0. Addresses 1 and 3 return 0.
- R8: `shutdown` is 1 exactly when ACR bit 6 is 0 and `ext_run` is 0. It follows its inputs with a delay of one register.
- R9: A `commit` with no staged value starts no busy period.
- R10: A reset loads `wiper_code` from the stored value, and the stored value keeps what was last committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse from the serial front end |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| commit | input | 1 | Chip-select-rise strobe |
| ext_run | input | 1 | External run input, high keeps the part active |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| wiper_code | output | 7 | Live wiper code |
| nv_busy | output | 1 | Programming in progress |
| shutdown | output | 1 | Active-high shutdown |

## Verification
A corrupted select bit shows on the next read of address 0: it returns the live code where the stored code was expected, or the reverse. A commit then either fails to raise `nv_busy` or raises it when it should not. A busy counter that is off by one changes the measured high time of `nv_busy`. A leaking write guard moves `wiper_code` on the cycle after a refused write. A stored register that is lost or reset shows as a wrong `wiper_code` on the first cycle after reset.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_WIPER = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;
  localparam int BIT_SEL  = 7;
  localparam int BIT_RUN  = 6;
  localparam int BIT_BUSY = 5;
  typedef struct packed {
    logic sel;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int TICKS = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      cnt_q  <= LAST;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/wiper_ctrl_reg.sv
module wiper_ctrl_reg
  import wrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.sel <= 1'b0;
      ctrl_q.run <= 1'b1;
    end else if (we) begin
      ctrl_q.sel <= wdata[BIT_SEL];
      ctrl_q.run <= wdata[BIT_RUN];
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/wiper_pair.sv
module wiper_pair #(
  parameter int WW = 7,
  parameter logic [WW-1:0] NV_DEFAULT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          stage_en,
  input  logic [WW-1:0] wdata,
  input  logic          commit,
  input  logic          busy,
  output logic          commit_go,
  output logic [WW-1:0] wiper,
  output logic [WW-1:0] stored
);
  logic [WW-1:0] wiper_q;
  logic [WW-1:0] pend_val_q;
  logic          pend_q;
  logic [WW-1:0] nv_q = NV_DEFAULT;

  assign commit_go = commit && pend_q && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_q <= nv_q;
      pend_q  <= 1'b0;
    end else begin
      if (wr_en) wiper_q <= wdata;
      if (stage_en) begin
        pend_q     <= 1'b1;
        pend_val_q <= wdata;
      end else if (commit_go) begin
        pend_q <= 1'b0;
      end
    end
  end

  // the stored cell keeps its content across reset
  always_ff @(posedge clk) begin
    if (commit_go) nv_q <= pend_val_q;
  end

  assign wiper  = wiper_q;
  assign stored = nv_q;
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
  import wrc_pkg::*;
#(
  parameter int WW = 7,
  parameter int BUSY_TICKS = 1000000,
  parameter logic [WW-1:0] NV_DEFAULT = 7'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              commit,
  input  logic              ext_run,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [WW-1:0]     wiper_code,
  output logic              nv_busy,
  output logic              shutdown
);
  localparam int PAD = DATA_W - WW;

  ctrl_t         ctrl;
  logic          busy;
  logic          commit_go;
  logic [WW-1:0] wiper;
  logic [WW-1:0] stored;
  logic          wr_ok;
  logic          wr_wiper;
  logic          wr_ctrl;

  assign wr_ok    = req_valid && req_write && !busy;
  assign wr_wiper = wr_ok && (req_addr == ADDR_WIPER);
  assign wr_ctrl  = wr_ok && (req_addr == ADDR_CTRL);

  wiper_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ctrl),
    .wdata (req_wdata),
    .ctrl  (ctrl)
  );

  wiper_pair #(.WW(WW), .NV_DEFAULT(NV_DEFAULT)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_wiper),
    .stage_en  (wr_wiper && !ctrl.sel),
    .wdata     (req_wdata[WW-1:0]),
    .commit    (commit),
    .busy      (busy),
    .commit_go (commit_go),
    .wiper     (wiper),
    .stored    (stored)
  );

  wiper_busy_timer #(.TICKS(BUSY_TICKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (commit_go),
    .busy  (busy)
  );

  logic [DATA_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view           = '0;
    ctrl_view[BIT_SEL]  = ctrl.sel;
    ctrl_view[BIT_RUN]  = ctrl.run;
    ctrl_view[BIT_BUSY] = busy;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (req_addr)
      ADDR_WIPER: rd_mux = {{PAD{1'b0}}, (ctrl.sel ? wiper : stored)};
      ADDR_CTRL:  rd_mux = ctrl_view;
      default:    rd_mux = '0;
    endcase
  end

  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              shdn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      shdn_q     <= 1'b0;
    end else begin
      rd_valid_q <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data_q <= rd_mux;
      shdn_q <= !(ctrl.run || ext_run);
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign wiper_code = wiper;
  assign nv_busy    = busy;
  assign shutdown   = shdn_q;
endmodule

// File: rtl/wiper_regfile_chk.sv
module wiper_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_write,
  input logic [1:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       commit,
  input logic       ext_run,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [6:0] wiper_code,
  input logic       nv_busy,
  input logic       shutdown
);
  p_busy_blocks_wiper_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && nv_busy) |=> $stable(wiper_code));

  p_write_moves_wiper_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == 2'd0 && !nv_busy)
      |=> wiper_code == $past(req_wdata[6:0]));

  p_ctrl_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == 2'd2) |=> rd_data[4:0] == 5'd0);

  p_busy_from_commit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(nv_busy) |-> $past(commit));

  p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  p_run_pin_r8: assert property (@(posedge clk) disable iff (rst)
    ext_run |=> !shutdown);
endmodule

bind wiper_regfile wiper_regfile_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .commit     (commit),
  .ext_run    (ext_run),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .wiper_code (wiper_code),
  .nv_busy    (nv_busy),
  .shutdown   (shutdown)
);

// File: tb/wiper_regfile_test.sv
module wiper_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 40;
  localparam logic [6:0] NV0 = 7'h2A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       commit = 1'b0;
  logic       ext_run = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [6:0] wiper_code;
  logic       nv_busy;
  logic       shutdown;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_regfile #(.WW(7), .BUSY_TICKS(TICKS), .NV_DEFAULT(NV0)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .commit(commit),
    .ext_run(ext_run), .rd_valid(rd_valid), .rd_data(rd_data),
    .wiper_code(wiper_code), .nv_busy(nv_busy), .shutdown(shutdown)
  );

  // vector: {kind(1=read check,0=write), addr[1:0], data[7:0], expect[7:0]}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'hC0, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hC0},
    {1'b0, 2'd0, 8'h15, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h15},
    {1'b0, 2'd0, 8'hFF, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h7F},
    {1'b0, 2'd2, 8'hE0, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hC0},
    {1'b0, 2'd2, 8'h5F, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h40},
    {1'b1, 2'd0, 8'h00, {1'b0, NV0}},
    {1'b1, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (rd_valid !== 1'b1) begin
      total++; bad++;
      $display("FAIL R7 rd_valid actual=%0b expected=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic pulse_commit();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 wiper", wiper_code, NV0);
    check("R1 busy", nv_busy, 0);
    check("R1 shutdown", shutdown, 0);
    do_read(2'd2, r);
    check("R1 ctrl", r, 8'h40);

    // table walk: R2 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        do_read(VEC[i][17:16], r);
        check("R2/R4/R6/R7 vector", r, VEC[i][7:0]);
      end else begin
        do_write(VEC[i][17:16], VEC[i][15:8]);
      end
    end
    check("R2 wiper port", wiper_code, 7'h7F);
    check("R2 no busy", nv_busy, 0);

    // R9 commit without staged value
    pulse_commit();
    check("R9 no busy", nv_busy, 0);

    // R3 staged write then commit
    do_write(2'd0, 8'h33);
    check("R3 wiper", wiper_code, 7'h33);
    do_read(2'd0, r);
    check("R3 stored before commit", r, {1'b0, NV0});
    pulse_commit();
    check("R3 busy", nv_busy, 1);
    do_read(2'd2, r);
    check("R4 busy bit", r, 8'h60);
    // R5 writes refused while busy
    do_write(2'd0, 8'h11);
    check("R5 wiper held", wiper_code, 7'h33);
    do_write(2'd2, 8'h80);
    do_read(2'd2, r);
    check("R5 ctrl held", r, 8'h60);
    repeat (TICKS + 5) @(negedge clk);
    check("R3 busy ends", nv_busy, 0);
    do_read(2'd2, r);
    check("R4 busy clear", r, 8'h40);
    do_read(2'd0, r);
    check("R3 stored", r, 8'h33);

    // R3 busy duration
    do_write(2'd0, 8'h34);
    pulse_commit();
    n = 0;
    while (nv_busy && n < TICKS + 10) begin
      n++;
      @(negedge clk);
    end
    check("R3 duration", n, TICKS);

    // R8 shutdown
    do_write(2'd2, 8'h00);
    @(negedge clk);
    check("R8 shutdown both low", shutdown, 1);
    ext_run = 1'b1;
    @(negedge clk);
    check("R8 pin releases", shutdown, 0);
    ext_run = 1'b0;
    do_write(2'd2, 8'h40);
    @(negedge clk);
    check("R8 bit releases", shutdown, 0);

    // R10 reset reloads from stored value
    do_write(2'd2, 8'h80);
    do_write(2'd0, 8'h05);
    check("R10 wiper pre", wiper_code, 7'h05);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reload", wiper_code, 7'h34);
    do_read(2'd2, r);
    check("R10 ctrl", r, 8'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule